// File: doc/BRIEF.md
# Smart-Card Interface Status Register

This block gathers the event and state signals of a smart-card serial interface into one 32-bit status word. The host reads that word through a simple read port. Timer expiry events and a receive-line silence event are held in sticky flags. Each sticky flag is cleared by the host read that returns it, and the read returns the value the flag had before the clear. The card reset pin level and the transmit shift-register state are passed through live.

A transmit-buffer-empty bit has two meanings, chosen by a FIFO mode input. Without the FIFO, the bit is a register. It is set when a byte moves from the buffer into the shift register, and it is cleared when the host writes the buffer. In FIFO mode, the bit follows the FIFO-empty input. A level interrupt request is raised while this bit is 1 and its enable input is 1.

The serial engine, the timers and the FIFO storage are outside this block. They supply the event pulses and the levels.

Top module: `smc_status_reg`

## Requirements
- R1: The bits of `rd_data` that carry no status always read 0. These are bits 31 down to 8+NUM_TIMERS and bits 3 down to 0.
- R2: A 1-cycle pulse on `tmr_tout[i]` sets bit 8+i of `rd_data` from the next cycle on. The bit stays set until a host read clears it. With the default of 3 timers, bits 10, 9 and 8 belong to timers 2, 1 and 0.
- R3: While `rd_strobe` is high, `rd_data` shows the flag values from before the clear. The sticky flags that had no set event in that cycle read 0 from the next cycle on.
- R4: If a set event and `rd_strobe` occur in the same cycle, the flag is 1 in the next cycle.
- R5: Bit 7 of `rd_data` equals `card_rst_pin` in the same cycle.
- R6: Bit 6 of `rd_data` equals `tx_shift_empty` in the same cycle.
- R7: With `fifo_mode` = 0, bit 5 becomes 1 in the cycle after a `tx_load` pulse. It becomes 0 in the cycle after a `tx_wr` pulse. When both occur in the same cycle, `tx_wr` wins.
- R8: With `fifo_mode` = 1, bit 5 equals `tx_fifo_empty` in the same cycle.
- R9: A pulse on `rx_silent` sets bit 4 from the next cycle on. Bit 4 is cleared by a host read in the same way as the timer flags, and a simultaneous set wins.
- R10: `tbe_irq` equals bit 5 of `rd_data` ANDed with `tbe_irq_en`, in the same cycle.
- R11: After a synchronous reset, all sticky flags are 0 and the non-FIFO buffer-empty register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tout | input | NUM_TIMERS | Timer expiry pulses |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| tx_load | input | 1 | Pulse: byte moved from buffer to shift register |
| fifo_mode | input | 1 | 1 selects FIFO mode |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| rx_silent | input | 1 | Pulse: receive line was silent for one full character time |
| card_rst_pin | input | 1 | Card reset pin level |
| rd_strobe | input | 1 | Host read of the status word |
| tx_wr | input | 1 | Host write into the transmit buffer or FIFO |
| tbe_irq_en | input | 1 | Buffer-empty interrupt enable |
| rd_data | output | 32 | Status word |
| tbe_irq | output | 1 | Buffer-empty interrupt request (level) |

## Verification
The bench builds the block with the default NUM_TIMERS = 3. This places the timer flags on bits 10..8 and leaves bits 31..11 as the reserved field. With that width, every timer can collide with a read in the same cycle. Random sparse pulses in both FIFO modes, with the interrupt enable toggling, reach the load/write collisions and the set-versus-clear races. Directed sequences first pin down the reset state, read-then-clear, and set-during-read.

// File: rtl/smc_stat_pkg.sv
package smc_stat_pkg;

    localparam int STAT_W     = 32;
    localparam int TMR_LSB    = 8;
    localparam int MAX_TIMERS = 16;
    localparam int POS_PIN    = 7;
    localparam int POS_TSE    = 6;
    localparam int POS_TBE    = 5;
    localparam int POS_SIL    = 4;

    typedef struct packed {
        logic pin;
        logic tse;
        logic tbe;
        logic sil;
    } live_bits_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [MAX_TIMERS-1:0] tmr,
        input live_bits_t            lb
    );
        logic [STAT_W-1:0] w;
        w = '0;
        w[TMR_LSB +: MAX_TIMERS] = tmr;
        w[POS_PIN] = lb.pin;
        w[POS_TSE] = lb.tse;
        w[POS_TBE] = lb.tbe;
        w[POS_SIL] = lb.sil;
        return w;
    endfunction

endpackage

// File: rtl/smc_sticky_flag.sv
module smc_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic rd_clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_ev)
            flag_q <= 1'b1;
        else if (rd_clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);                                   // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !set_ev) |=> !flag);                     // R3
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_clr) |=> flag);                        // R2

endmodule

// File: rtl/smc_tbe_tracker.sv
module smc_tbe_tracker (
    input  logic clk,
    input  logic rst,
    input  logic fifo_mode,
    input  logic fifo_empty,
    input  logic load_ev,
    input  logic host_wr,
    output logic tbe
);

    logic buf_empty_q;

    always_ff @(posedge clk) begin
        if (rst)
            buf_empty_q <= 1'b1;
        else if (host_wr)
            buf_empty_q <= 1'b0;
        else if (load_ev)
            buf_empty_q <= 1'b1;
    end

    assign tbe = fifo_mode ? fifo_empty : buf_empty_q;

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !fifo_mode) ##1 !fifo_mode |-> !tbe);   // R7
    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
        (load_ev && !host_wr && !fifo_mode) ##1 !fifo_mode |-> tbe); // R7
    AST_FIFO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_mode |-> (tbe == fifo_empty));                 // R8

endmodule

// File: rtl/smc_status_reg.sv
module smc_status_reg
    import smc_stat_pkg::*;
#(
    parameter int NUM_TIMERS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TIMERS-1:0] tmr_tout,
    input  logic                  tx_shift_empty,
    input  logic                  tx_load,
    input  logic                  fifo_mode,
    input  logic                  tx_fifo_empty,
    input  logic                  rx_silent,
    input  logic                  card_rst_pin,
    input  logic                  rd_strobe,
    input  logic                  tx_wr,
    input  logic                  tbe_irq_en,
    output logic [31:0]           rd_data,
    output logic                  tbe_irq
);

    localparam int TMR_MSB = TMR_LSB + NUM_TIMERS - 1;

    logic [MAX_TIMERS-1:0] tmr_flags;
    logic                  sil_flag;
    logic                  tbe_bit;
    live_bits_t            lb;

    generate
        for (genvar i = 0; i < MAX_TIMERS; i++) begin : g_tmr
            if (i < NUM_TIMERS) begin : g_used
                smc_sticky_flag u_flag (
                    .clk    (clk),
                    .rst    (rst),
                    .set_ev (tmr_tout[i]),
                    .rd_clr (rd_strobe),
                    .flag   (tmr_flags[i])
                );
            end else begin : g_unused
                assign tmr_flags[i] = 1'b0;
            end
        end
    endgenerate

    smc_sticky_flag u_silent (
        .clk    (clk),
        .rst    (rst),
        .set_ev (rx_silent),
        .rd_clr (rd_strobe),
        .flag   (sil_flag)
    );

    smc_tbe_tracker u_tbe (
        .clk        (clk),
        .rst        (rst),
        .fifo_mode  (fifo_mode),
        .fifo_empty (tx_fifo_empty),
        .load_ev    (tx_load),
        .host_wr    (tx_wr),
        .tbe        (tbe_bit)
    );

    always_comb begin
        lb.pin = card_rst_pin;
        lb.tse = tx_shift_empty;
        lb.tbe = tbe_bit;
        lb.sil = sil_flag;
    end

    assign rd_data = pack_status(tmr_flags, lb);
    assign tbe_irq = tbe_bit & tbe_irq_en;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:TMR_MSB+1] == '0) && (rd_data[3:0] == '0)); // R1
    AST_READ_SHOWS_OLD: assert property (@(posedge clk) disable iff (rst)
        (rd_data[POS_SIL] && rd_strobe && !rx_silent) |=> !rd_data[POS_SIL]); // R9
    AST_IRQ_NEEDS_TBE: assert property (@(posedge clk) disable iff (rst)
        tbe_irq |-> rd_data[POS_TBE]);                      // R10

endmodule

// File: tb/tb_smc_status_reg.sv
module tb_smc_status_reg;

    localparam int NT = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [NT-1:0] tmr_tout;
    logic          tx_shift_empty, tx_load, fifo_mode, tx_fifo_empty;
    logic          rx_silent, card_rst_pin, rd_strobe, tx_wr, tbe_irq_en;
    logic [31:0]   rd_data;
    logic          tbe_irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_tmr [NT];
    int m_sil;
    int m_tbe;

    always #4 clk = ~clk;   // 125 MHz

    smc_status_reg #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst(rst), .tmr_tout(tmr_tout),
        .tx_shift_empty(tx_shift_empty), .tx_load(tx_load),
        .fifo_mode(fifo_mode), .tx_fifo_empty(tx_fifo_empty),
        .rx_silent(rx_silent), .card_rst_pin(card_rst_pin),
        .rd_strobe(rd_strobe), .tx_wr(tx_wr), .tbe_irq_en(tbe_irq_en),
        .rd_data(rd_data), .tbe_irq(tbe_irq)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_tbe();
        return fifo_mode ? int'(tx_fifo_empty) : m_tbe;
    endfunction

    // Compare all outputs against the model (inputs already stable)
    task automatic compare_all();
        for (int i = 0; i < NT; i++)
            check("R2", $sformatf("timer flag %0d", i), rd_data[8+i], m_tmr[i]);
        check("R1", "reserved high", rd_data[31:8+NT], 0);
        check("R1", "reserved low", rd_data[3:0], 0);
        check("R5", "pin bit", rd_data[7], card_rst_pin);
        check("R6", "shift empty bit", rd_data[6], tx_shift_empty);
        check(fifo_mode ? "R8" : "R7", "buffer empty bit", rd_data[5], exp_tbe());
        check("R9", "silent flag", rd_data[4], m_sil);
        check("R10", "irq", tbe_irq, exp_tbe() & int'(tbe_irq_en));
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < NT; i++) m_tmr[i] = 0;
            m_sil = 0;
            m_tbe = 1;
        end else begin
            for (int i = 0; i < NT; i++)
                m_tmr[i] = (tmr_tout[i] || (m_tmr[i] != 0 && !rd_strobe)) ? 1 : 0;
            m_sil = (rx_silent || (m_sil != 0 && !rd_strobe)) ? 1 : 0;
            if (tx_wr) m_tbe = 0;
            else if (tx_load) m_tbe = 1;
        end
    endtask

    // one cycle: inputs were set at negedge; compare, then advance the model
    task automatic step();
        #1;
        if (!rst) compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        tmr_tout = '0; tx_load = 0; rx_silent = 0; rd_strobe = 0; tx_wr = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; idle_inputs();
        tx_shift_empty = 1; fifo_mode = 0; tx_fifo_empty = 1;
        card_rst_pin = 0; tbe_irq_en = 0;
        for (int i = 0; i < NT; i++) m_tmr[i] = 0;
        m_sil = 0; m_tbe = 1;
        @(negedge clk);
        step(); step();
        rst = 0;
        #1;
        // R11: reset state, bits 6 and 5 set, sticky flags clear
        check("R11", "reset word", rd_data, 32'h0000_0060);

        // timers and silent events set sticky flags
        tmr_tout = 3'b101; rx_silent = 1; step();
        idle_inputs(); step();
        #1;
        check("R2", "flags after pulses", rd_data[10:8], 3'b101);
        // R3: read returns old value, then clears
        rd_strobe = 1; #1;
        check("R3", "read shows pre-clear", rd_data[10:8], 3'b101);
        step();
        idle_inputs(); #1;
        check("R3", "flags cleared after read", rd_data[10:8], 3'b000);
        check("R9", "silent cleared after read", rd_data[4], 0);
        step();
        // R4: set and read in the same cycle keep the flag
        tmr_tout = 3'b010; rx_silent = 1; rd_strobe = 1; step();
        idle_inputs(); #1;
        check("R4", "set during read survives", rd_data[9], 1);
        check("R4", "silent set during read survives", rd_data[4], 1);
        step();
        // R7: write clears, load sets, write wins on collision
        tbe_irq_en = 1;
        tx_wr = 1; step(); idle_inputs(); #1;
        check("R7", "write clears tbe", rd_data[5], 0);
        check("R10", "irq low after write", tbe_irq, 0);
        tx_load = 1; step(); idle_inputs(); #1;
        check("R7", "load sets tbe", rd_data[5], 1);
        check("R10", "irq high", tbe_irq, 1);
        tx_load = 1; tx_wr = 1; step(); idle_inputs(); #1;
        check("R7", "write wins over load", rd_data[5], 0);
        // R8: FIFO mode follows empty input
        fifo_mode = 1; tx_fifo_empty = 0; #1;
        check("R8", "fifo not empty", rd_data[5], 0);
        tx_fifo_empty = 1; #1;
        check("R8", "fifo empty", rd_data[5], 1);
        // R5/R6 live pins
        card_rst_pin = 1; tx_shift_empty = 0; #1;
        check("R5", "pin high", rd_data[7], 1);
        check("R6", "shift busy", rd_data[6], 0);
        step();

        // random phase against the model
        for (int n = 0; n < 600; n++) begin
            tmr_tout       = NT'((($urandom % 6) == 0) ? $urandom : 0);
            rx_silent      = ($urandom % 7) == 0;
            rd_strobe      = ($urandom % 5) == 0;
            tx_wr          = ($urandom % 6) == 0;
            tx_load        = ($urandom % 5) == 0;
            card_rst_pin   = $urandom % 2;
            tx_shift_empty = $urandom % 2;
            tx_fifo_empty  = $urandom % 2;
            tbe_irq_en     = ($urandom % 3) != 0;
            if (($urandom % 40) == 0) fifo_mode = ~fifo_mode;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule